// File: doc/BRIEF.md
# Working-Set Clock Victim Selector

This block picks which physical frame to give up when a page fault arrives. It keeps a small circular table of frames. Each frame has a referenced flag, a modified flag and a last-use stamp taken from an external virtual-time counter. Memory accesses mark frames as referenced, and write accesses also mark them as modified. When a fault request arrives, a persistent hand walks the circle and examines one frame per clock cycle.

A frame that was referenced recently has its flag cleared and its stamp refreshed, and the hand moves on. A frame that has not been referenced and whose age is above the window `tau` is taken as the victim if it is clean. If such a frame is dirty, the block issues a writeback request for it instead. After a full lap the block applies one of two rules. If any writeback was seen, it keeps scanning until an acknowledged writeback makes a frame clean. If none was seen, it takes a fallback frame.

The chosen index is reported with a one-cycle valid pulse. The victim frame is then reloaded as freshly referenced and clean.

Top module: `wsclock_sel`

## Requirements
- R1: After reset, busy, victim_valid and wb_req are 0, the hand points at frame 0, and every frame has R=0, M=0 and stamp 0.
- R2: A cycle with acc_valid=1 sets R of frame acc_idx. If acc_write=1 in that cycle, it also sets M of that frame.
- R3: While searching, a frame under the hand with R=1 has R cleared and its stamp set to the current vtime, and the hand moves to the next frame (index NF-1 wraps to 0).
- R4: The age is (vtime - stamp) modulo 2^TW. A frame with R=0, age strictly greater than tau and M=0 is chosen as the victim at once.
- R5: A frame with R=0, age greater than tau and M=1 is skipped. If it has no writeback outstanding, a one-cycle wb_req pulse is issued with wb_idx equal to that frame. A frame never has more than one outstanding writeback.
- R6: wb_ack with wb_ack_idx clears M of that frame and ends its outstanding writeback.
- R7: If a full lap ends with no victim and at least one old dirty frame was seen, scanning continues, lap after lap, until an old clean frame is found.
- R8: If a full lap ends with no victim and no old dirty frame was seen, the victim is the first frame seen with M=0 in that lap, counting from the hand's starting frame. If there is no such frame, the victim is the starting frame.
- R9: A victim is reported by a single-cycle victim_valid pulse with victim_idx. In the same cycle busy drops, the hand moves to the frame after the victim, and the victim gets R=1, M=0 and stamp = vtime.
- R10: busy rises in the cycle after an accepted fault_req. The frame k steps from the hand is examined in the k-th busy cycle, so a victim found there pulses victim_valid k+2 cycles after fault_req is sampled. A fallback victim pulses NF+1 cycles after fault_req is sampled.
- R11: fault_req is ignored while busy=1 and does not start a later search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Memory access strobe |
| acc_write | input | 1 | Access is a write |
| acc_idx | input | IW | Frame index of the access |
| vtime | input | TW | Current virtual time |
| tau | input | TW | Working-set window |
| fault_req | input | 1 | Start a victim search |
| busy | output | 1 | Search in progress |
| victim_valid | output | 1 | One-cycle pulse: victim_idx is valid |
| victim_idx | output | IW | Chosen frame |
| wb_req | output | 1 | One-cycle writeback request pulse |
| wb_idx | output | IW | Frame to write back |
| wb_ack | input | 1 | Writeback completed |
| wb_ack_idx | input | IW | Frame whose writeback completed |

## Verification
A wrong hand position or a wrong flag shows at the next fault as a different victim index, or as a writeback request for an unexpected frame. Both appear within one lap, NF+1 cycles. A stale stamp or a wrong age comparison moves the choice from one branch to another, for example a fallback where a direct pick was expected. It also changes the victim latency, which the bench checks exactly. A lost outstanding-writeback mark shows as a duplicate request. A lost modified clear shows as a search that never ends once the writeback has been acknowledged.

// File: rtl/wsclock_sel.sv
module wsclock_sel #(
  parameter int NF = 8,
  parameter int TW = 8,
  localparam int IW = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [IW-1:0] acc_idx,
  input  logic [TW-1:0] vtime,
  input  logic [TW-1:0] tau,
  input  logic          fault_req,
  output logic          busy,
  output logic          victim_valid,
  output logic [IW-1:0] victim_idx,
  output logic          wb_req,
  output logic [IW-1:0] wb_idx,
  input  logic          wb_ack,
  input  logic [IW-1:0] wb_ack_idx
);

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] h);
    return (h == IW'(NF - 1)) ? '0 : h + 1'b1;
  endfunction

  logic [NF-1:0] r_q, m_q, p_q;
  logic [TW-1:0] t_q [NF];
  logic [IW-1:0] hand, cnt, fb_i;
  logic          fb_v, seen_q;

  logic [TW-1:0] age;
  logic          cur_r, cur_m, old, pick_now, issue, seen_now, last, pick_fb, done;
  logic [IW-1:0] vsel;

  assign cur_r    = r_q[hand];
  assign cur_m    = m_q[hand];
  assign age      = vtime - t_q[hand];
  assign old      = age > tau;
  assign pick_now = busy && !cur_r && old && !cur_m;
  assign seen_now = busy && !cur_r && old && cur_m;
  assign issue    = seen_now && !p_q[hand];
  assign last     = busy && (cnt == IW'(NF - 1));
  assign pick_fb  = last && !pick_now && !(seen_q || seen_now);
  assign done     = pick_now || pick_fb;
  assign vsel     = pick_now ? hand :
                    fb_v     ? fb_i :
                    !cur_m   ? hand : nxt(hand);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_q <= '0;
      m_q <= '0;
      p_q <= '0;
      for (int i = 0; i < NF; i++) t_q[i] <= '0;
    end else begin
      for (int i = 0; i < NF; i++) begin
        if (acc_valid && acc_idx == IW'(i))           r_q[i] <= 1'b1;
        else if (done && vsel == IW'(i))              r_q[i] <= 1'b1;
        else if (busy && cur_r && hand == IW'(i))     r_q[i] <= 1'b0;

        if (acc_valid && acc_write && acc_idx == IW'(i)) m_q[i] <= 1'b1;
        else if (done && vsel == IW'(i))                 m_q[i] <= 1'b0;
        else if (wb_ack && wb_ack_idx == IW'(i))         m_q[i] <= 1'b0;

        if (issue && hand == IW'(i))                  p_q[i] <= 1'b1;
        else if (wb_ack && wb_ack_idx == IW'(i))      p_q[i] <= 1'b0;

        if (done && vsel == IW'(i))                   t_q[i] <= vtime;
        else if (busy && cur_r && hand == IW'(i))     t_q[i] <= vtime;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      hand         <= '0;
      cnt          <= '0;
      fb_v         <= 1'b0;
      fb_i         <= '0;
      seen_q       <= 1'b0;
      victim_valid <= 1'b0;
      victim_idx   <= '0;
      wb_req       <= 1'b0;
      wb_idx       <= '0;
    end else begin
      victim_valid <= 1'b0;
      wb_req       <= issue;
      if (issue) wb_idx <= hand;
      if (!busy) begin
        if (fault_req) begin
          busy   <= 1'b1;
          cnt    <= '0;
          fb_v   <= 1'b0;
          seen_q <= 1'b0;
        end
      end else if (done) begin
        busy         <= 1'b0;
        victim_valid <= 1'b1;
        victim_idx   <= vsel;
        hand         <= nxt(vsel);
      end else begin
        hand   <= nxt(hand);
        cnt    <= last ? '0 : cnt + 1'b1;
        seen_q <= seen_q || seen_now;
        if (!fb_v && !cur_m) begin
          fb_v <= 1'b1;
          fb_i <= hand;
        end
      end
    end
  end

endmodule

module wsclock_sel_chk #(
  parameter int NF = 8,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fault_req,
  input logic          busy,
  input logic          victim_valid,
  input logic [IW-1:0] victim_idx,
  input logic          wb_req,
  input logic [IW-1:0] wb_idx,
  input logic          wb_ack,
  input logic [IW-1:0] wb_ack_idx,
  input logic          acc_valid,
  input logic          acc_write,
  input logic [IW-1:0] acc_idx,
  input logic [IW-1:0] hand,
  input logic [NF-1:0] m_q
);

  p_victim_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |=> !victim_valid);

  p_idle_at_victim_r9: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> !busy);

  p_hand_past_victim_r9: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> hand == ((victim_idx == IW'(NF - 1)) ? '0 : victim_idx + 1'b1));

  p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && fault_req) |=> busy);

  p_victim_from_search_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(victim_valid) |-> $past(busy));

  p_no_dup_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |=> !(wb_req && wb_idx == $past(wb_idx)));

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_ack && !(acc_valid && acc_write && acc_idx == wb_ack_idx)) |=> !m_q[$past(wb_ack_idx)]);

endmodule

bind wsclock_sel wsclock_sel_chk #(.NF(NF), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fault_req(fault_req), .busy(busy),
  .victim_valid(victim_valid), .victim_idx(victim_idx),
  .wb_req(wb_req), .wb_idx(wb_idx), .wb_ack(wb_ack), .wb_ack_idx(wb_ack_idx),
  .acc_valid(acc_valid), .acc_write(acc_write), .acc_idx(acc_idx),
  .hand(hand), .m_q(m_q)
);

// File: tb/wsclock_sel_test.sv
module wsclock_sel_test;
  localparam int NF = 8;
  localparam int TW = 8;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0, fault_req = 0, wb_ack = 0;
  logic [IW-1:0] acc_idx = 0, wb_ack_idx = 0;
  logic [TW-1:0] vtime = 0, tau = 0;
  logic busy, victim_valid, wb_req;
  logic [IW-1:0] victim_idx, wb_idx;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  wsclock_sel #(.NF(NF), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_idx(acc_idx), .vtime(vtime), .tau(tau), .fault_req(fault_req),
    .busy(busy), .victim_valid(victim_valid), .victim_idx(victim_idx),
    .wb_req(wb_req), .wb_idx(wb_idx), .wb_ack(wb_ack), .wb_ack_idx(wb_ack_idx)
  );

  bit mR[NF], mM[NF], mP[NF];
  logic [TW-1:0] mT[NF];
  int mh;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic access(input int idx, input bit wr);
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_idx = IW'(idx);
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
    mR[idx] = 1;
    if (wr) mM[idx] = 1;
  endtask

  task automatic ack(input int idx);
    @(negedge clk);
    wb_ack = 1; wb_ack_idx = IW'(idx);
    @(negedge clk);
    wb_ack = 0;
    mM[idx] = 0; mP[idx] = 0;
  endtask

  task automatic run_fault(input logic [TW-1:0] vt, input logic [TW-1:0] tv,
                           input bit extra, input string tag);
    int ev, ek, wbn, gotn, cyc, start, fbi;
    bit found, seen, fbv, need, got;
    int wbl[NF];
    int gotl[NF];
    logic [TW-1:0] age;
    string vtag;
    start = mh; fbv = 0; fbi = 0; seen = 0; found = 0; wbn = 0; need = 0;
    ev = 0; ek = NF - 1;
    for (int k = 0; k < NF; k++) begin
      int f = (start + k) % NF;
      if (!found) begin
        age = vt - mT[f];
        if (mR[f]) begin
          mR[f] = 0; mT[f] = vt;
        end else if (age > tv) begin
          if (!mM[f]) begin
            found = 1; ev = f; ek = k;
          end else begin
            seen = 1;
            if (!mP[f]) begin mP[f] = 1; wbl[wbn] = f; wbn++; end
          end
        end
        if (!found && !fbv && !mM[f]) begin fbv = 1; fbi = f; end
      end
    end
    if (!found) begin
      if (seen) begin need = 1; ev = wbl[0]; end
      else ev = fbv ? fbi : start;
    end
    vtag = (tag != "") ? tag : need ? "R7" : found ? "R4" : "R8";

    @(negedge clk);
    vtime = vt; tau = tv; fault_req = 1;
    cyc = 0; got = 0; gotn = 0;
    while (!got && cyc < 4 * NF + 40) begin
      @(negedge clk);
      cyc++;
      fault_req = extra && (cyc == 3);
      wb_ack = need && (cyc == 2 * NF + 3);
      wb_ack_idx = IW'(ev);
      if (wb_req && gotn < NF) begin gotl[gotn] = int'(wb_idx); gotn++; end
      if (victim_valid) got = 1;
    end
    wb_ack = 0; fault_req = 0;
    check(got, {vtag, " victim reported"}, int'(got), 1);
    check(int'(victim_idx) == ev, {vtag, " victim index"}, int'(victim_idx), ev);
    if (!need)
      check(cyc == ek + 2, "R10 victim latency", cyc, ek + 2);
    else
      check(got, "R6 acked frame made clean", int'(victim_idx), ev);
    check(gotn == wbn, "R5 writeback count", gotn, wbn);
    for (int i = 0; i < wbn && i < gotn; i++)
      check(gotl[i] == wbl[i], "R5 writeback index", gotl[i], wbl[i]);

    mR[ev] = 1; mM[ev] = 0; mT[ev] = vt; mP[ev] = 0;
    mh = (ev + 1) % NF;

    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!victim_valid && !busy, extra ? "R11 fault ignored while busy" : "R9 single pulse",
            int'(victim_valid) + int'(busy), 0);
    end
    for (int i = 0; i < NF; i++) if (mP[i]) ack(i);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [TW-1:0] vt;
    void'($urandom(32'd4242));
    for (int i = 0; i < NF; i++) begin mR[i] = 0; mM[i] = 0; mP[i] = 0; mT[i] = 0; end
    mh = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !victim_valid && !wb_req, "R1 outputs idle after reset",
          int'(busy) + int'(victim_valid) + int'(wb_req), 0);

    run_fault(8'd100, 8'd10, 0, "R1");
    access(1, 0);
    run_fault(8'd100, 8'd10, 0, "R3");
    access(4, 1);
    run_fault(8'd100, 8'd10, 0, "R2");
    run_fault(8'd110, 8'd10, 0, "");
    for (int i = 0; i < NF; i++) access(i, 1);
    run_fault(8'd120, 8'd5, 0, "R8");
    run_fault(8'd240, 8'd20, 1, "R7");

    vt = 8'd240;
    for (int it = 0; it < 80; it++) begin
      int na = $urandom_range(0, 6);
      for (int a = 0; a < na; a++) access($urandom_range(0, NF - 1), 1'($urandom_range(0, 1)));
      vt = vt + 8'($urandom_range(0, 40));
      run_fault(vt, 8'($urandom_range(0, 60)), (it % 7) == 0, "");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule